// File: doc/BRIEF.md
# Pixel Cluster Finder Matrix

The block holds a hardware image of a pixel sensor slice: one small state machine per pixel, arranged as ROWS by COLS. Hit addresses arrive one per clock while the block is idle and mark their cells. A scan request then starts the cluster search. The block seeds a cluster at the left-most occupied column, taking the top-most hit in that column. It spreads the selection through all hit cells that touch the seed along a side or at a corner. It then streams the selected pixels out as row and column addresses, emptying each cell as it leaves. This repeats until no hits remain. The run time grows with the number of hits, not with the square of it.

The slice is a circular buffer along the column direction. A window step empties the current first column and moves the first-column pointer by one. The old logical columns 1..COLS-1 become 0..COLS-2, and a fresh empty column appears at logical COLS-1. No cell data moves. All addresses at the ports are logical: they count from the current first column.

Controller states and transitions:
- IDLE: accepts hits, window steps and module starts. On a scan request it moves to SEED.
- SEED: if a hit remains, it marks the seed and moves to GROW. Otherwise it returns to IDLE.
- GROW: lets the selection spread for exactly ROWS*COLS cycles, then moves to READ.
- READ: emits one selected pixel per cycle. After the last pixel of the cluster it returns to SEED.
- A module-start pulse in any state returns the controller to IDLE.

Top module: `cf_matrix`

## Requirements
- R1: After reset, busy and pix_valid are 0, every cell is empty, and a scan emits no pixels.
- R2: While idle, a hit_valid cycle marks the cell at logical (hit_row, hit_col). A repeated hit on an occupied cell is ignored, so that pixel is read out once.
- R3: Clusters are emitted in seed order. Each seed is the lowest logical column holding a hit, and within that column the lowest row.
- R4: A cluster contains exactly the hits connected to its seed through chains of 8-neighbour contact (side or corner).
- R5: Within a cluster, pixels come out one per cycle on consecutive cycles, ordered by ascending logical column and then ascending row. Each pixel appears once and its cell is emptied.
- R6: pix_last is 1 on the final pixel of each cluster and 0 on every other cycle. The cycle after pix_last carries no pixel.
- R7: A mod_start pulse empties every cell, resets the first-column pointer to 0 and returns the block to idle on the next cycle.
- R8: A win_step pulse while idle empties logical column 0 and renumbers logical column k+1 as k. The new logical column COLS-1 is empty. Logical columns 0 and COLS-1 are never treated as neighbours.
- R9: busy rises the cycle after scan_go and falls only once the slice is empty. Hits presented while busy are ignored. pix_valid is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_start | input | 1 | Empty all cells and reset the window pointer |
| win_step | input | 1 | Slide the window by one column (used when idle) |
| hit_valid | input | 1 | Hit address present |
| hit_row | input | $clog2(ROWS) | Hit row |
| hit_col | input | $clog2(COLS) | Hit logical column |
| scan_go | input | 1 | Start the cluster search |
| busy | output | 1 | Search in progress |
| pix_valid | output | 1 | Output pixel present |
| pix_row | output | $clog2(ROWS) | Output pixel row |
| pix_col | output | $clog2(COLS) | Output pixel logical column |
| pix_last | output | 1 | Final pixel of the current cluster |

## Verification
The bench builds the block as 16 rows by 8 columns. At that size a full-slice cluster of 128 pixels, every window pointer position and the seam between the last and first logical columns can all be reached in a short run. A flood-fill model in the bench predicts every output beat for diagonal chains, split clusters in one column, a full slice and pseudo-random sparse images. Window steps come before each random image, so the pointer rotates through all eight positions.

// File: rtl/cf_pkg.sv
package cf_pkg;
    typedef enum logic [1:0] {
        CELL_EMPTY = 2'b00,
        CELL_HIT   = 2'b01,
        CELL_SEL   = 2'b10
    } cell_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEED,
        ST_GROW,
        ST_READ
    } fsm_t;
endpackage

// File: rtl/cf_cell.sv
module cf_cell
    import cf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  wr,
    input  logic  seed,
    input  logic  grow,
    input  logic  nbr,
    input  logic  take,
    output cell_t st
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= CELL_EMPTY;
        end else if (clr) begin
            st <= CELL_EMPTY;
        end else begin
            unique case (st)
                CELL_EMPTY: if (wr) st <= CELL_HIT;
                CELL_HIT:   if (seed || (grow && nbr)) st <= CELL_SEL;
                CELL_SEL:   if (take) st <= CELL_EMPTY;
                default:    st <= CELL_EMPTY;
            endcase
        end
    end
endmodule

// File: rtl/cf_prio.sv
module cf_prio #(
    parameter int ROWS = 16,
    parameter int COLS = 8,
    localparam int N  = ROWS * COLS,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col
);
    // mask index = logical_col * ROWS + row; the lowest set index wins
    always_comb begin
        found = 1'b0;
        row   = '0;
        col   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                row   = RW'(i % ROWS);
                col   = CW'(i / ROWS);
            end
        end
    end
endmodule

// File: rtl/cf_matrix.sv
module cf_matrix
    import cf_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 8,
    localparam int N  = ROWS * COLS,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mod_start,
    input  logic          win_step,
    input  logic          hit_valid,
    input  logic [RW-1:0] hit_row,
    input  logic [CW-1:0] hit_col,
    input  logic          scan_go,
    output logic          busy,
    output logic          pix_valid,
    output logic [RW-1:0] pix_row,
    output logic [CW-1:0] pix_col,
    output logic          pix_last
);
    localparam int GROW_LEN = N;
    localparam int GW = (GROW_LEN > 1) ? $clog2(GROW_LEN) : 1;

    fsm_t          state_q, state_d;
    logic [GW-1:0] cnt_q;
    logic [CW-1:0] first_q;

    cell_t         cst [ROWS][COLS];
    logic [ROWS+1:0] spad [COLS];
    logic [N-1:0]  hit_l, sel_l, sel_rest;

    logic          seed_found, rd_found, rd_last;
    logic [RW-1:0] seed_row, rd_row;
    logic [CW-1:0] seed_lcol, rd_lcol;
    logic [CW-1:0] hit_pcol, seed_pcol, rd_pcol;

    logic adv_clr, hit_we, seed_en, grow_en, take_en;

    function automatic logic [CW-1:0] to_phys(input logic [CW-1:0] l, input logic [CW-1:0] f);
        int s;
        s = int'(l) + int'(f);
        if (s >= COLS) s = s - COLS;
        return CW'(s);
    endfunction

    // gather physical cell states into logical masks and padded select columns
    always_comb begin
        hit_l = '0;
        sel_l = '0;
        for (int c = 0; c < COLS; c++) begin
            spad[c] = '0;
            for (int r = 0; r < ROWS; r++) begin
                spad[c][r+1] = (cst[r][c] == CELL_SEL);
            end
        end
        for (int l = 0; l < COLS; l++) begin
            for (int r = 0; r < ROWS; r++) begin
                hit_l[l*ROWS+r] = (cst[r][to_phys(CW'(l), first_q)] == CELL_HIT);
                sel_l[l*ROWS+r] = (cst[r][to_phys(CW'(l), first_q)] == CELL_SEL);
            end
        end
    end

    // first chain: seed among hits
    cf_prio #(.ROWS(ROWS), .COLS(COLS)) u_seed_chain (
        .mask(hit_l), .found(seed_found), .row(seed_row), .col(seed_lcol)
    );

    // second chain: readout among selected cells
    cf_prio #(.ROWS(ROWS), .COLS(COLS)) u_read_chain (
        .mask(sel_l), .found(rd_found), .row(rd_row), .col(rd_lcol)
    );

    always_comb begin
        sel_rest = sel_l;
        sel_rest[int'(rd_lcol) * ROWS + int'(rd_row)] = 1'b0;
        rd_last  = ~|sel_rest;
    end

    assign hit_pcol  = to_phys(hit_col, first_q);
    assign seed_pcol = to_phys(seed_lcol, first_q);
    assign rd_pcol   = to_phys(rd_lcol, first_q);

    // controller: next state and cell strobes
    always_comb begin
        state_d = state_q;
        adv_clr = 1'b0;
        hit_we  = 1'b0;
        seed_en = 1'b0;
        grow_en = 1'b0;
        take_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                adv_clr = win_step;
                hit_we  = !win_step && hit_valid && (int'(hit_row) < ROWS);
                if (!win_step && scan_go) state_d = ST_SEED;
            end
            ST_SEED: begin
                seed_en = seed_found;
                state_d = seed_found ? ST_GROW : ST_IDLE;
            end
            ST_GROW: begin
                grow_en = 1'b1;
                if (cnt_q == GW'(GROW_LEN - 1)) state_d = ST_READ;
            end
            ST_READ: begin
                take_en = rd_found;
                if (!rd_found || rd_last) state_d = ST_SEED;
            end
            default: state_d = ST_IDLE;
        endcase
        if (mod_start) begin
            state_d = ST_IDLE;
            adv_clr = 1'b0;
            hit_we  = 1'b0;
            seed_en = 1'b0;
            grow_en = 1'b0;
            take_en = 1'b0;
        end
    end

    // cell array with 8-neighbour links; the seam before first_q is cut
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int CL = (c == 0) ? COLS - 1 : c - 1;
            localparam int CR = (c == COLS - 1) ? 0 : c + 1;
            logic ok_l, ok_r, nbr, clr, wr, sd, tk;
            assign ok_l = (first_q != CW'(c));
            assign ok_r = (first_q != CW'(CR));
            assign nbr  = (ok_l && (|spad[CL][r+2:r])) ||
                          (ok_r && (|spad[CR][r+2:r])) ||
                          spad[c][r] || spad[c][r+2];
            assign clr  = mod_start || (adv_clr && (first_q == CW'(c)));
            assign wr   = hit_we  && (hit_row  == RW'(r)) && (hit_pcol  == CW'(c));
            assign sd   = seed_en && (seed_row == RW'(r)) && (seed_pcol == CW'(c));
            assign tk   = take_en && (rd_row   == RW'(r)) && (rd_pcol   == CW'(c));
            cf_cell u_cell (
                .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr), .seed(sd),
                .grow(grow_en), .nbr(nbr), .take(tk), .st(cst[r][c])
            );
        end
    end

    // state register, grow counter and window pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            first_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SEED) cnt_q <= '0;
            else if (grow_en)       cnt_q <= cnt_q + 1'b1;
            if (mod_start) begin
                first_q <= '0;
            end else if (adv_clr) begin
                first_q <= (int'(first_q) == COLS - 1) ? '0 : first_q + 1'b1;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_row   <= '0;
            pix_col   <= '0;
            pix_last  <= 1'b0;
        end else begin
            pix_valid <= take_en;
            pix_row   <= rd_row;
            pix_col   <= rd_lcol;
            pix_last  <= take_en && rd_last;
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/cf_matrix_chk.sv
module cf_matrix_chk #(
    parameter int RW = 4,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mod_start,
    input logic          busy,
    input logic          pix_valid,
    input logic [RW-1:0] pix_row,
    input logic [CW-1:0] pix_col,
    input logic          pix_last
);
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pix_last |-> pix_valid); // R6

    AST_LAST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        pix_last |=> !pix_valid); // R6

    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> busy); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !pix_valid); // R9

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mod_start |=> !busy); // R7

    AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && !$past(pix_last)) |->
        ((pix_col > $past(pix_col)) ||
         ((pix_col == $past(pix_col)) && (pix_row > $past(pix_row))))); // R5
endmodule

bind cf_matrix cf_matrix_chk #(.RW(RW), .CW(CW)) u_cf_matrix_chk (
    .clk(clk), .rst_n(rst_n), .mod_start(mod_start), .busy(busy),
    .pix_valid(pix_valid), .pix_row(pix_row), .pix_col(pix_col), .pix_last(pix_last)
);

// File: tb/test_cf_matrix.sv
module test_cf_matrix;
    localparam int R  = 16;
    localparam int C  = 8;
    localparam int N  = R * C;
    localparam int RW = $clog2(R);
    localparam int CW = $clog2(C);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mod_start = 1'b0, win_step = 1'b0, hit_valid = 1'b0, scan_go = 1'b0;
    logic [RW-1:0] hit_row = '0;
    logic [CW-1:0] hit_col = '0;
    logic busy, pix_valid, pix_last;
    logic [RW-1:0] pix_row;
    logic [CW-1:0] pix_col;

    int checks = 0;
    int errors = 0;
    bit mdl [R][C];
    int exp_r [N];
    int exp_c [N];
    int exp_l [N];
    int n_exp;
    int unsigned rng = 32'h1234_5679;

    always #2 clk = ~clk;

    cf_matrix #(.ROWS(R), .COLS(C)) i_cf_matrix (
        .clk(clk), .rst_n(rst_n), .mod_start(mod_start), .win_step(win_step),
        .hit_valid(hit_valid), .hit_row(hit_row), .hit_col(hit_col),
        .scan_go(scan_go), .busy(busy), .pix_valid(pix_valid),
        .pix_row(pix_row), .pix_col(pix_col), .pix_last(pix_last)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int unsigned nxt();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    task automatic put_hit(input int r, input int c);
        hit_valid = 1'b1;
        hit_row = RW'(r);
        hit_col = CW'(c);
        @(negedge clk);
        hit_valid = 1'b0;
        mdl[r][c] = 1'b1;
    endtask

    task automatic do_start();
        mod_start = 1'b1;
        @(negedge clk);
        mod_start = 1'b0;
        for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) mdl[r][c] = 1'b0;
    endtask

    task automatic do_step();
        win_step = 1'b1;
        @(negedge clk);
        win_step = 1'b0;
        for (int r = 0; r < R; r++) begin
            for (int c = 0; c < C - 1; c++) mdl[r][c] = mdl[r][c+1];
            mdl[r][C-1] = 1'b0;
        end
    endtask

    // flood-fill reference: seed order, 8-neighbour growth, column-major readout
    task automatic build_expected();
        bit work [R][C];
        bit mark [R][C];
        bit found, changed;
        int sr, sc;
        n_exp = 0;
        for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) work[r][c] = mdl[r][c];
        while (1) begin
            found = 0;
            sr = 0;
            sc = 0;
            for (int c = 0; c < C; c++)
                for (int r = 0; r < R; r++)
                    if (!found && work[r][c]) begin found = 1; sr = r; sc = c; end
            if (!found) break;
            for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) mark[r][c] = 0;
            mark[sr][sc] = 1;
            changed = 1;
            while (changed) begin
                changed = 0;
                for (int r = 0; r < R; r++)
                    for (int c = 0; c < C; c++)
                        if (work[r][c] && !mark[r][c])
                            for (int dr = -1; dr <= 1; dr++)
                                for (int dc = -1; dc <= 1; dc++)
                                    if (r+dr >= 0 && r+dr < R && c+dc >= 0 && c+dc < C)
                                        if (mark[r+dr][c+dc] && !mark[r][c]) begin
                                            mark[r][c] = 1;
                                            changed = 1;
                                        end
            end
            for (int c = 0; c < C; c++)
                for (int r = 0; r < R; r++)
                    if (mark[r][c]) begin
                        exp_r[n_exp] = r;
                        exp_c[n_exp] = c;
                        exp_l[n_exp] = 0;
                        n_exp++;
                        work[r][c] = 0;
                    end
            exp_l[n_exp-1] = 1;
        end
    endtask

    task automatic run_scan(input string req, input bit inject);
        int idx = 0;
        int cyc = 0;
        build_expected();
        scan_go = 1'b1;
        @(negedge clk);
        scan_go = 1'b0;
        chk(busy == 1'b1, "R9", "busy after scan_go", int'(busy), 1);
        if (inject) begin
            hit_valid = 1'b1;
            hit_row = '0;
            hit_col = '0;
        end
        while (busy && cyc < 4000) begin
            if (pix_valid) begin
                if (idx < n_exp) begin
                    chk(int'(pix_row) == exp_r[idx] && int'(pix_col) == exp_c[idx] &&
                        int'(pix_last) == exp_l[idx], req, "beat row*1000+col*10+last",
                        int'(pix_row)*1000 + int'(pix_col)*10 + int'(pix_last),
                        exp_r[idx]*1000 + exp_c[idx]*10 + exp_l[idx]);
                end else begin
                    chk(1'b0, req, "extra beat row*1000+col", int'(pix_row)*1000 + int'(pix_col), -1);
                end
                idx++;
            end
            @(negedge clk);
            hit_valid = 1'b0;
            cyc++;
        end
        chk(!busy, "R9", "busy falls (watchdog)", int'(busy), 0);
        chk(idx == n_exp, "R3", "beat count", idx, n_exp);
        for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) mdl[r][c] = 1'b0;
    endtask

    initial begin
        repeat (200000 - 200) @(posedge clk);
        chk(1'b0, "R9", "global watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) mdl[r][c] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(pix_valid == 1'b0, "R1", "pix_valid after reset", int'(pix_valid), 0);
        run_scan("R1", 1'b0);

        // R2 single pixel, R6 last flag
        put_hit(5, 3);
        run_scan("R2", 1'b0);

        // R4 diagonal corner contact
        put_hit(0, 0); put_hit(1, 1); put_hit(2, 2); put_hit(3, 3);
        run_scan("R4", 1'b0);

        // R3 seed order: two clusters in one column, one to the right
        put_hit(4, 1); put_hit(2, 1); put_hit(0, 2);
        run_scan("R3", 1'b0);

        // R2 duplicate hit ignored
        put_hit(7, 4); put_hit(7, 4);
        run_scan("R2", 1'b0);

        // R5 full slice as one cluster
        for (int c = 0; c < C; c++) for (int r = 0; r < R; r++) put_hit(r, c);
        run_scan("R5", 1'b0);

        // R5 serpentine cluster needing many growth steps
        for (int c = 0; c < C; c += 2) for (int r = 0; r < R; r++) put_hit(r, c);
        for (int c = 1; c < C; c += 2) put_hit(((c / 2) % 2 == 0) ? R - 1 : 0, c);
        run_scan("R5", 1'b0);

        // R7 module start clears hits
        put_hit(3, 3); put_hit(9, 6);
        do_start();
        run_scan("R7", 1'b0);

        // R9 hit presented while busy is ignored
        put_hit(10, 5);
        run_scan("R9", 1'b1);
        run_scan("R9", 1'b0);

        // R8 window step drops column 0, renumbers, no seam contact
        do_start();
        put_hit(1, 0); put_hit(1, 1); put_hit(9, 7);
        do_step();
        put_hit(1, 7);
        put_hit(2, 6);
        run_scan("R8", 1'b0);

        // R4 R8 pseudo-random sparse images at every pointer position
        for (int k = 0; k < 30; k++) begin
            int nh;
            do_step();
            nh = 1 + int'(nxt() % 12);
            for (int h = 0; h < nh; h++) put_hit(int'(nxt() % R), int'(nxt() % C));
            run_scan((k % 2 == 0) ? "R4" : "R8", 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule